// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block keeps time of day and calendar date as packed BCD bytes (tens digit in bits 7:4, units digit in bits 3:0) behind a byte-wide register bus. A one-cycle pulse on `tick_en`, produced once per second by an external prescaler, advances the time. Seconds carry into minutes, minutes into hours, hours into the day of the month, and so on up through the month and a two-digit year. A binary weekday counter steps with every day rollover. Software reads any field at any time; the read path is combinational from the address. A write replaces one field in a single cycle.

A control byte starts and stops counting and switches the hour register between 24-hour and 12-hour presentation. It also carries a one-shot request to snap the time to the nearest minute, and an enable for hourly drift compensation. A 16-bit compensation value is loaded one byte at a time. When compensation is enabled, that value is handed to the prescaler as a signed correction, together with a one-cycle valid strobe, each time the clock reaches a full hour (MM:SS = 00:00).

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the fields read as follows: seconds, minutes, hours, year and weekday 0x00; day 0x01; month 0x01. Control reads 0x00 and both compensation bytes read 0x00.
- R2: The time registers sit at byte addresses 0x00 (seconds), 0x04 (minutes), 0x08 (hours), 0x0C (day), 0x10 (month) and 0x14 (year). Each is packed BCD. A write stores the data masked to the field width. Each accepted tick counts seconds from 00 to 59, then wraps them to 00 and carries into minutes. Minutes carry into hours after 59, and hours wrap from 23 to 00 with a carry into the day.
- R3: The day wraps to 01 after the last day of the current month: 30 for months 04, 06, 09 and 11; 28 for month 02, or 29 when the BCD year is divisible by 4; 31 for all other months. When it wraps, it carries into the month.
- R4: The month wraps from 12 to 01 with a carry into the year, and the year wraps from 99 to 00. The weekday at 0x18 reads as plain binary 0..6. It advances on every day rollover and wraps from 6 to 0. Writes to 0x18 leave it unchanged.
- R5: While the run bit is 0, ticks leave every time field unchanged.
- R6: When the 12-hour bit is 1, the hour register reads with bit 7 as the PM flag (set for hours 12 to 23), bit 6 as 0, and a BCD hour of 01 to 12 in bits 5:0. Midnight reads 0x12 with the PM flag clear.
- R7: When the 12-hour bit is 1, a write to the hour register takes the BCD hour from bits 5:0 (with 12 standing for 0) and adds 12 when bit 7 is set. After this write the 24-hour view shows the result.
- R8: A round request clears the seconds to 00. If the seconds were 30 or more, it also advances the minute with full carry. It takes effect on the first cycle after the request with no bus write, whether or not the run bit is set, and no tick is taken in that cycle.
- R9: The round bit reads 1 while a request is pending and clears itself once the rounding is applied.
- R10: The compensation value is written as a low byte at 0x4C and a high byte at 0x50, and both bytes read back as written.
- R11: When the auto-compensation bit is 1 and a tick or a rounding carries the time to MM:SS = 00:00, `comp_valid` is high for one cycle alongside the new time, and `comp_value` holds the compensation value. No strobe occurs while the bit is 0.
- R12: In a cycle with any bus write, a tick is dropped. The written field takes the written value, and no other time field moves.
- R13: The control register at 0x40 has the following bits: bit 0 run, bit 1 round request, bit 2 auto-compensation, bit 3 12-hour mode. Bits 7:4 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-second advance pulse, one cycle wide |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| comp_valid | output | 1 | One-cycle strobe at each full hour when compensation is enabled |
| comp_value | output | COMP_W | Signed compensation correction for the prescaler |

## Verification
The bench builds the block with its defaults: an 8-bit address, a 16-bit compensation value and a seven-day week. The full-width compensation value can therefore carry a negative correction (0xFE34) onto the strobe. The short week lets the bench reach the weekday wrap with only a few forced midnights. Because every field is writable, the bench can reach year-end, leap and short-month boundaries in a handful of ticks rather than waiting through real time. Tick-versus-write collisions and round requests that fall on a minute boundary are also driven directly.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  // Register byte addresses; software depends on these positions.
  localparam logic [7:0] OFS_SEC     = 8'h00;
  localparam logic [7:0] OFS_MIN     = 8'h04;
  localparam logic [7:0] OFS_HOUR    = 8'h08;
  localparam logic [7:0] OFS_DAY     = 8'h0C;
  localparam logic [7:0] OFS_MONTH   = 8'h10;
  localparam logic [7:0] OFS_YEAR    = 8'h14;
  localparam logic [7:0] OFS_WDAY    = 8'h18;
  localparam logic [7:0] OFS_CTRL    = 8'h40;
  localparam logic [7:0] OFS_COMP_LO = 8'h4C;
  localparam logic [7:0] OFS_COMP_HI = 8'h50;

  // Writable time field indices.
  localparam int F_SEC    = 0;
  localparam int F_MIN    = 1;
  localparam int F_HOUR   = 2;
  localparam int F_DAY    = 3;
  localparam int F_MONTH  = 4;
  localparam int F_YEAR   = 5;
  localparam int N_FIELDS = 6;

  localparam logic [7:0] FIELD_OFS [N_FIELDS] =
    '{OFS_SEC, OFS_MIN, OFS_HOUR, OFS_DAY, OFS_MONTH, OFS_YEAR};

  // Control bit positions.
  localparam int CTL_RUN   = 0;
  localparam int CTL_ROUND = 1;
  localparam int CTL_AUTO  = 2;
  localparam int CTL_H12   = 3;
  localparam int CTL_W     = 4;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } tod_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] bcd2bin(input logic [7:0] v);
    return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [7:0] v);
    logic [7:0] t;
    logic [7:0] u;
    t = v / 8'd10;
    u = v % 8'd10;
    return {t[3:0], u[3:0]};
  endfunction

  // Last day of a BCD month; a BCD year divisible by 4 is a leap year.
  function automatic logic [7:0] month_last(input logic [7:0] month,
                                            input logic [7:0] year);
    logic leap;
    if (year[4]) leap = (year[3:0] == 4'd2) || (year[3:0] == 4'd6);
    else         leap = (year[3:0] == 4'd0) || (year[3:0] == 4'd4) ||
                        (year[3:0] == 4'd8);
    case (month)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
#(
  parameter int DAYS_PER_WEEK = 7,
  localparam int WDAY_W = $clog2(DAYS_PER_WEEK)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                run,
  input  logic                round_req,
  input  logic                wr_any,
  input  logic [N_FIELDS-1:0] wr_sel,
  input  logic [7:0]          wr_data,
  output tod_t                tod_q,
  output logic [WDAY_W-1:0]   wday_q,
  output logic                round_done,
  output logic                hour_roll
);

  tod_t              tod_d;
  logic [WDAY_W-1:0] wday_d;
  logic              round_go, tick_go;
  logic              min_inc, hour_inc, day_inc, mon_inc, year_inc;

  always_comb begin
    tod_d    = tod_q;
    wday_d   = wday_q;
    round_go = round_req && !wr_any;
    tick_go  = tick_en && run && !wr_any && !round_go;
    min_inc  = 1'b0;

    // Seconds: rounding wins over a tick in the same cycle.
    if (round_go) begin
      tod_d.sec = 8'h00;
      min_inc   = (tod_q.sec >= 8'h30);
    end else if (tick_go) begin
      if (tod_q.sec >= 8'h59) begin
        tod_d.sec = 8'h00;
        min_inc   = 1'b1;
      end else begin
        tod_d.sec = bcd_inc(tod_q.sec);
      end
    end

    hour_inc = min_inc && (tod_q.min >= 8'h59);
    if (min_inc) tod_d.min = hour_inc ? 8'h00 : bcd_inc(tod_q.min);

    day_inc = hour_inc && (tod_q.hour >= 8'h23);
    if (hour_inc) tod_d.hour = day_inc ? 8'h00 : bcd_inc(tod_q.hour);

    mon_inc = day_inc && (tod_q.day >= month_last(tod_q.month, tod_q.year));
    if (day_inc) begin
      tod_d.day = mon_inc ? 8'h01 : bcd_inc(tod_q.day);
      wday_d    = (wday_q >= WDAY_W'(DAYS_PER_WEEK - 1)) ? '0 : wday_q + 1'b1;
    end

    year_inc = mon_inc && (tod_q.month >= 8'h12);
    if (mon_inc) tod_d.month = year_inc ? 8'h01 : bcd_inc(tod_q.month);
    if (year_inc) tod_d.year = (tod_q.year >= 8'h99) ? 8'h00 : bcd_inc(tod_q.year);

    // Bus writes (tick and rounding are already blocked in this cycle).
    if (wr_sel[F_SEC])   tod_d.sec   = {1'b0,  wr_data[6:0]};
    if (wr_sel[F_MIN])   tod_d.min   = {1'b0,  wr_data[6:0]};
    if (wr_sel[F_HOUR])  tod_d.hour  = {2'b00, wr_data[5:0]};
    if (wr_sel[F_DAY])   tod_d.day   = {2'b00, wr_data[5:0]};
    if (wr_sel[F_MONTH]) tod_d.month = {3'b000, wr_data[4:0]};
    if (wr_sel[F_YEAR])  tod_d.year  = wr_data;
  end

  assign round_done = round_go;
  assign hour_roll  = hour_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tod_q  <= '{year: 8'h00, month: 8'h01, day: 8'h01,
                  hour: 8'h00, min: 8'h00, sec: 8'h00};
      wday_q <= '0;
    end else begin
      tod_q  <= tod_d;
      wday_q <= wday_d;
    end
  end

endmodule

// File: rtl/rtc_hour_fmt.sv
module rtc_hour_fmt
  import rtc_pkg::*;
(
  input  logic       mode12,
  input  logic [7:0] hour24,
  input  logic [7:0] wdata,
  output logic [7:0] rd_hour,
  output logic [7:0] wr_hour
);

  logic [7:0] h_bin, h12_bin, h12_bcd;
  logic [7:0] w_bin, w24_bin, w24_bcd;
  logic       pm;

  always_comb begin
    // Read side: 24-hour BCD to PM flag plus 01..12.
    h_bin   = bcd2bin(hour24);
    pm      = (h_bin >= 8'd12);
    h12_bin = h_bin % 8'd12;
    if (h12_bin == 8'd0) h12_bin = 8'd12;
    h12_bcd = bin2bcd(h12_bin);

    // Write side: PM flag plus 01..12 to 24-hour BCD.
    w_bin   = bcd2bin({2'b00, wdata[5:0]}) % 8'd12;
    w24_bin = w_bin + (wdata[7] ? 8'd12 : 8'd0);
    w24_bcd = bin2bcd(w24_bin);

    rd_hour = mode12 ? {pm, 1'b0, h12_bcd[5:0]} : hour24;
    wr_hour = mode12 ? w24_bcd : wdata;
  end

endmodule

// File: rtl/rtc_comp_export.sv
module rtc_comp_export #(
  parameter int COMP_W = 16,
  localparam int HI_W = COMP_W - 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_lo,
  input  logic                     we_hi,
  input  logic [7:0]               wdata,
  input  logic                     auto_en,
  input  logic                     hour_roll,
  output logic [COMP_W-1:0]        comp_q,
  output logic                     comp_valid,
  output logic signed [COMP_W-1:0] comp_value
);

  logic [COMP_W-1:0] comp_d, val_q, val_d;
  logic              pulse_d, pulse_q;

  always_comb begin
    comp_d = comp_q;
    if (we_lo) comp_d[7:0]        = wdata;
    if (we_hi) comp_d[COMP_W-1:8] = wdata[HI_W-1:0];
    pulse_d = hour_roll && auto_en;
    val_d   = pulse_d ? comp_q : val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comp_q  <= '0;
      val_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      comp_q  <= comp_d;
      val_q   <= val_d;
      pulse_q <= pulse_d;
    end
  end

  assign comp_valid = pulse_q;
  assign comp_value = signed'(val_q);

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int COMP_W        = 16,
  parameter int DAYS_PER_WEEK = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_en,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_we,
  input  logic [7:0]               bus_wdata,
  output logic [7:0]               bus_rdata,
  output logic                     comp_valid,
  output logic signed [COMP_W-1:0] comp_value
);

  localparam int WDAY_W = $clog2(DAYS_PER_WEEK);

  logic                rst_q;
  logic [CTL_W-1:0]    ctrl_q, ctrl_d;
  logic                ctrl_run, ctrl_round, ctrl_auto, ctrl_h12;
  logic [N_FIELDS-1:0] field_sel;
  logic                ctrl_sel, comp_lo_sel, comp_hi_sel;
  logic [7:0]          hour_rd, hour_wr, core_wdata;
  tod_t                tod_q;
  logic [WDAY_W-1:0]   wday_q;
  logic                round_done, hour_roll;
  logic [COMP_W-1:0]   comp_q;

  rtc_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q)
  );

  // Address decode for the six writable time fields.
  for (genvar gi = 0; gi < N_FIELDS; gi++) begin : g_dec
    assign field_sel[gi] = bus_we && (bus_addr == ADDR_W'(FIELD_OFS[gi]));
  end

  assign ctrl_sel    = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
  assign comp_lo_sel = bus_we && (bus_addr == ADDR_W'(OFS_COMP_LO));
  assign comp_hi_sel = bus_we && (bus_addr == ADDR_W'(OFS_COMP_HI));

  assign ctrl_run   = ctrl_q[CTL_RUN];
  assign ctrl_round = ctrl_q[CTL_ROUND];
  assign ctrl_auto  = ctrl_q[CTL_AUTO];
  assign ctrl_h12   = ctrl_q[CTL_H12];

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_sel)        ctrl_d = bus_wdata[CTL_W-1:0];
    else if (round_done) ctrl_d[CTL_ROUND] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  rtc_hour_fmt u_hfmt (
    .mode12  (ctrl_h12),
    .hour24  (tod_q.hour),
    .wdata   (bus_wdata),
    .rd_hour (hour_rd),
    .wr_hour (hour_wr)
  );

  assign core_wdata = field_sel[F_HOUR] ? hour_wr : bus_wdata;

  rtc_time_core #(.DAYS_PER_WEEK(DAYS_PER_WEEK)) u_time (
    .clk        (clk),
    .rst_n      (rst_q),
    .tick_en    (tick_en),
    .run        (ctrl_run),
    .round_req  (ctrl_round),
    .wr_any     (bus_we),
    .wr_sel     (field_sel),
    .wr_data    (core_wdata),
    .tod_q      (tod_q),
    .wday_q     (wday_q),
    .round_done (round_done),
    .hour_roll  (hour_roll)
  );

  rtc_comp_export #(.COMP_W(COMP_W)) u_comp (
    .clk        (clk),
    .rst_n      (rst_q),
    .we_lo      (comp_lo_sel),
    .we_hi      (comp_hi_sel),
    .wdata      (bus_wdata),
    .auto_en    (ctrl_auto),
    .hour_roll  (hour_roll),
    .comp_q     (comp_q),
    .comp_valid (comp_valid),
    .comp_value (comp_value)
  );

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFS_SEC):     bus_rdata = tod_q.sec;
      ADDR_W'(OFS_MIN):     bus_rdata = tod_q.min;
      ADDR_W'(OFS_HOUR):    bus_rdata = hour_rd;
      ADDR_W'(OFS_DAY):     bus_rdata = tod_q.day;
      ADDR_W'(OFS_MONTH):   bus_rdata = tod_q.month;
      ADDR_W'(OFS_YEAR):    bus_rdata = tod_q.year;
      ADDR_W'(OFS_WDAY):    bus_rdata = 8'(wday_q);
      ADDR_W'(OFS_CTRL):    bus_rdata = 8'(ctrl_q);
      ADDR_W'(OFS_COMP_LO): bus_rdata = comp_q[7:0];
      ADDR_W'(OFS_COMP_HI): bus_rdata = 8'(comp_q[COMP_W-1:8]);
      default:              bus_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/rtc_bcd_checker.sv
module rtc_bcd_checker
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WDAY_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              run,
  input logic              round_pend,
  input logic              auto_comp,
  input tod_t              tod,
  input logic [WDAY_W-1:0] wday,
  input logic              comp_valid
);

  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && run && !bus_we && !round_pend && tod.sec == 8'h59)
      |=> (tod.sec == 8'h00));

  assert_wday_ro_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> $stable(wday));

  assert_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !round_pend && !bus_we) |=> $stable(tod));

  assert_round_sec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (round_pend && !bus_we) |=> (tod.sec == 8'h00));

  assert_round_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (round_pend && !bus_we) |=> !round_pend);

  assert_hour_mark_R11: assert property (@(posedge clk) disable iff (!rst_n)
    comp_valid |-> (tod.sec == 8'h00 && tod.min == 8'h00 && $past(auto_comp)));

  assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && tick_en && bus_addr == ADDR_W'(OFS_SEC))
      |=> (tod.sec == {1'b0, $past(bus_wdata[6:0])}));

endmodule

bind rtc_bcd_core rtc_bcd_checker #(.ADDR_W(ADDR_W), .WDAY_W(WDAY_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q),
  .tick_en    (tick_en),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .run        (ctrl_run),
  .round_pend (ctrl_round),
  .auto_comp  (ctrl_auto),
  .tod        (tod_q),
  .wday       (wday_q),
  .comp_valid (comp_valid)
);

// File: tb/test_rtc_bcd_core.sv
`timescale 1ns/1ps
module test_rtc_bcd_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        comp_valid;
  logic signed [15:0] comp_value;

  always #2.5 clk = ~clk;

  rtc_bcd_core i_rtc_bcd_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .comp_valid (comp_valid),
    .comp_value (comp_value)
  );

  typedef struct {
    logic [7:0] addr;
    logic [7:0] exp;
    string      tag;
  } rd_item_t;

  rd_item_t    rq[$];
  logic [15:0] cq[$];
  int total = 0;
  int bad = 0;
  int exp_wday = 0;
  bit done = 1'b0;

  // Monitor: compares reads and compensation strobes against the queues.
  always @(negedge clk) begin
    rd_item_t it;
    logic [15:0] e;
    if (rq.size() > 0) begin
      it = rq.pop_front();
      total++;
      if (bus_rdata !== it.exp) begin
        bad++;
        $display("FAIL %s addr=%02h actual=%02h expected=%02h",
                 it.tag, it.addr, bus_rdata, it.exp);
      end
    end
    if (comp_valid === 1'b1) begin
      total++;
      if (cq.size() == 0) begin
        bad++;
        $display("FAIL R11 unexpected strobe actual=%04h expected=none", comp_value);
      end else begin
        e = cq.pop_front();
        if (comp_value !== e) begin
          bad++;
          $display("FAIL R11 value actual=%04h expected=%04h", comp_value, e);
        end
      end
    end
  end

  task automatic idle();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic tick();
    tick_en = 1'b1;
    @(posedge clk); #1;
    tick_en = 1'b0;
  endtask

  task automatic chk(input logic [7:0] a, input logic [7:0] e, input string tag);
    rd_item_t it;
    bus_addr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    rq.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(8'h08, h); wr(8'h04, m); wr(8'h00, s);
  endtask

  task automatic set_date(input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y);
    wr(8'h0C, d); wr(8'h10, mo); wr(8'h14, y);
  endtask

  task automatic midnight();
    set_time(8'h23, 8'h59, 8'h59);
    tick();
    exp_wday = (exp_wday + 1) % 7;
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) idle();

    // R1 reset state
    chk(8'h00, 8'h00, "R1 sec");
    chk(8'h04, 8'h00, "R1 min");
    chk(8'h08, 8'h00, "R1 hour");
    chk(8'h0C, 8'h01, "R1 day");
    chk(8'h10, 8'h01, "R1 month");
    chk(8'h14, 8'h00, "R1 year");
    chk(8'h18, 8'h00, "R1 wday");
    chk(8'h40, 8'h00, "R1 ctrl");
    chk(8'h4C, 8'h00, "R1 comp lo");
    chk(8'h50, 8'h00, "R1 comp hi");

    // R13 control layout, run bit
    wr(8'h40, 8'hF1);
    chk(8'h40, 8'h01, "R13 ctrl upper bits zero");

    // R2 full carry chain, R4 year wrap
    set_date(8'h31, 8'h12, 8'h99);
    set_time(8'h23, 8'h59, 8'h58);
    tick();
    chk(8'h00, 8'h59, "R2 sec step");
    tick();
    exp_wday = 1;
    chk(8'h00, 8'h00, "R2 sec wrap");
    chk(8'h04, 8'h00, "R2 min wrap");
    chk(8'h08, 8'h00, "R2 hour wrap");
    chk(8'h0C, 8'h01, "R3 day wrap dec");
    chk(8'h10, 8'h01, "R4 month wrap");
    chk(8'h14, 8'h00, "R4 year wrap");
    chk(8'h18, 8'h01, "R4 wday step");
    wr(8'h00, 8'hFF);
    chk(8'h00, 8'h7F, "R2 masked write");

    // R3 leap and short months
    set_date(8'h28, 8'h02, 8'h24);
    midnight();
    chk(8'h0C, 8'h29, "R3 leap feb 29");
    midnight();
    chk(8'h0C, 8'h01, "R3 leap feb end");
    chk(8'h10, 8'h03, "R3 leap march");
    set_date(8'h28, 8'h02, 8'h23);
    midnight();
    chk(8'h0C, 8'h01, "R3 plain feb end");
    chk(8'h10, 8'h03, "R3 plain march");
    set_date(8'h30, 8'h04, 8'h23);
    midnight();
    chk(8'h0C, 8'h01, "R3 april end");
    chk(8'h10, 8'h05, "R3 may");

    // R4 weekday ignores writes, then wraps
    wr(8'h18, 8'h03);
    chk(8'h18, 8'(exp_wday), "R4 wday write ignored");
    while (exp_wday != 0) midnight();
    chk(8'h18, 8'h00, "R4 wday wrap");

    // R5 stopped
    wr(8'h40, 8'h00);
    set_time(8'h10, 8'h20, 8'h30);
    tick(); tick();
    chk(8'h00, 8'h30, "R5 halted sec");
    wr(8'h40, 8'h01);

    // R6 / R7 12-hour mode
    wr(8'h08, 8'h00);
    wr(8'h40, 8'h09);
    chk(8'h08, 8'h12, "R6 midnight");
    wr(8'h40, 8'h01);
    wr(8'h08, 8'h13);
    wr(8'h40, 8'h09);
    chk(8'h08, 8'h81, "R6 1pm");
    wr(8'h08, 8'h85);
    chk(8'h08, 8'h85, "R7 pm5 12h view");
    wr(8'h40, 8'h01);
    chk(8'h08, 8'h17, "R7 pm5 24h view");
    wr(8'h40, 8'h09);
    wr(8'h08, 8'h12);
    wr(8'h40, 8'h01);
    chk(8'h08, 8'h00, "R7 12am");
    wr(8'h40, 8'h09);
    wr(8'h08, 8'h92);
    wr(8'h40, 8'h01);
    chk(8'h08, 8'h12, "R7 12pm");

    // R8 / R9 rounding
    set_time(8'h05, 8'h10, 8'h29);
    wr(8'h40, 8'h03);
    chk(8'h40, 8'h03, "R9 round pending");
    chk(8'h00, 8'h00, "R8 round down sec");
    chk(8'h04, 8'h10, "R8 round down min");
    chk(8'h40, 8'h01, "R9 round cleared");
    set_time(8'h05, 8'h59, 8'h30);
    wr(8'h40, 8'h03);
    idle();
    chk(8'h00, 8'h00, "R8 round up sec");
    chk(8'h04, 8'h00, "R8 round up min");
    chk(8'h08, 8'h06, "R8 round up hour");
    wr(8'h40, 8'h00);
    set_time(8'h07, 8'h00, 8'h45);
    wr(8'h40, 8'h02);
    idle();
    chk(8'h04, 8'h01, "R8 round while stopped");
    chk(8'h40, 8'h00, "R9 round cleared stopped");
    wr(8'h40, 8'h01);

    // R10 compensation bytes
    wr(8'h4C, 8'h34);
    wr(8'h50, 8'hFE);
    chk(8'h4C, 8'h34, "R10 comp lo");
    chk(8'h50, 8'hFE, "R10 comp hi");

    // R11 hourly export
    set_time(8'h08, 8'h59, 8'h59);
    tick();
    chk(8'h08, 8'h09, "R11 no strobe when off");
    wr(8'h40, 8'h05);
    set_time(8'h08, 8'h30, 8'h59);
    tick();
    set_time(8'h08, 8'h59, 8'h59);
    cq.push_back(16'hFE34);
    tick();
    idle();
    total++;
    if (cq.size() != 0) begin
      bad++;
      $display("FAIL R11 strobe missing actual=0 expected=1");
    end

    // R12 write beats tick
    wr(8'h40, 8'h01);
    set_time(8'h10, 8'h10, 8'h10);
    bus_we = 1'b1; bus_addr = 8'h00; bus_wdata = 8'h42; tick_en = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0; tick_en = 1'b0;
    chk(8'h00, 8'h42, "R12 write wins");
    chk(8'h04, 8'h10, "R12 min still");
    bus_we = 1'b1; bus_addr = 8'h14; bus_wdata = 8'h07; tick_en = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0; tick_en = 1'b0;
    chk(8'h00, 8'h42, "R12 tick dropped");
    chk(8'h14, 8'h07, "R12 other field written");

    idle(); idle();
    done = 1'b1;
    report();
    $finish;
  end

endmodule